// File: doc/BRIEF.md
# Codec Serial Port with On-Demand Control Slot

This block is the device end of a synchronous serial link between a telephony codec and a DSP, working as the clock master. It divides the master clock to make the bit clock (`sclk`). It marks each frame of 256 bit periods with a frame pulse (`fsync`). At the start of every frame, a 16-bit primary slot moves one transmit sample from the DSP on `sdi` and one receive sample to the DSP on `sdo`.

A second 16-bit slot, beginning 128 bit periods into the frame, is added only in frames where the DSP asks for it. That slot carries a single command that reads or writes one 8-bit control register. A request is raised either by the least significant bit of the transmit word or by the hardware flag input `fc`. The register file drives the rest of the codec through `reg_out`, and one of its bits chooses between the two ways of making a request.

Top module: `csp_serial_port`

## Requirements
- R1: `sclk` has a period of 2*HALF `mclk` cycles. A frame lasts 256 `sclk` periods. `fsync` is high for exactly the first bit period of every frame, and the block drives and samples data on `sclk` rising and falling edges respectively.
- R2: `sdo` carries `rx_sample`, as captured at the start of the frame, in bit periods 0 to 15, MSB first.
- R3: In bit periods 0 to 15, `sdi` is assembled MSB first into `tx_sample`, with a one-cycle `tx_strobe` after bit 15. In 15-bit mode (the reset mode), the LSB of `tx_sample` is forced to 0.
- R4: In 15-bit mode, a secondary slot is opened in the same frame if the transmit LSB is 1 or `fc` is high when the last primary bit is sampled. `fsync` then also pulses in bit period 128.
- R5: When bit 0 of register 1 is 1 (16-bit mode), only `fc` requests a secondary slot. The transmit LSB is then ordinary data and is passed through to `tx_sample`.
- R6: In a frame without a request, `fsync` stays low at bit period 128, `sdo` stays 0 outside the primary slot, and `sdi` has no effect on the registers.
- R7: The secondary command on `sdi` is MSB first. Bit 15 is read/write (1 = read), bits 14:13 are ignored, bits 12:8 are the address, and bits 7:0 are the data. When bit 15 is 0, the addressed register takes the data at the end of the slot. A read changes no register.
- R8: In a read, `sdo` is 0 in bit periods 128 to 135 and carries the addressed register, MSB first, in bit periods 136 to 143. In a write, `sdo` is 0 for the whole slot.
- R9: An address at or above NREG reads back as 0x00, and a write to it changes no register.
- R10: After reset, all registers are 0x00, the block is in 15-bit mode, and `sclk`, `fsync`, `sdo` and `tx_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from the DSP |
| fc | input | 1 | Hardware request for a secondary slot |
| rx_sample | input | 16 | Receive sample to be sent in the next frame |
| sclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame / secondary slot sync pulse |
| sdo | output | 1 | Serial data to the DSP |
| tx_sample | output | 16 | Last received transmit sample |
| tx_strobe | output | 1 | One-cycle pulse when `tx_sample` updates |
| reg_out | output | NREG*8 | Control register contents, register i in bits 8i+7:8i |

## Verification
The hardest state to reach is 16-bit mode, where a set transmit LSB must be ignored. It can only be entered through a secondary write to register 1, which needs a request made the other way first. The bench uses an LSB-requested write to set the mode bit. In the next frame it sends an LSB of 1 together with a complete write command on `sdi`, and checks that no slot pulse appears and the target register keeps its value. It then turns to `fc` to read the mode register back.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int SLOT_W = 16;
  localparam int ADDR_W = 5;
  localparam int SB_REG = 1;
  localparam int SB_BIT = 0;

  // Secondary request decision at the end of the primary slot
  function automatic logic csp_request(input logic sb, input logic lsb, input logic fc);
    return fc | (~sb & lsb);
  endfunction

  // Transmit sample as delivered to the datapath
  function automatic logic [SLOT_W-1:0] csp_tx_mask(input logic [SLOT_W-1:0] w, input logic sb);
    return sb ? w : {w[SLOT_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/csp_clkgen.sv
module csp_clkgen #(
  parameter int HALF = 1
) (
  input  logic mclk,
  input  logic rst_n,
  output logic sclk,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] hcnt;
  logic          toggle;

  assign toggle  = (hcnt == LAST);
  assign rise_ev = toggle & ~sclk;
  assign fall_ev = toggle & sclk;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      sclk <= 1'b0;
    end else if (toggle) begin
      hcnt <= '0;
      sclk <= ~sclk;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/csp_regfile.sv
module csp_regfile #(
  parameter int NREG = 8
) (
  input  logic                      mclk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [csp_pkg::ADDR_W-1:0] wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [csp_pkg::ADDR_W-1:0] rd_addr,
  output logic [7:0]                rd_data,
  output logic [NREG*8-1:0]         regs
);
  localparam int AW = csp_pkg::ADDR_W;

  logic [7:0] reg_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n)                             reg_q[i] <= 8'h00;
      else if (wr_en && wr_addr == AW'(i))    reg_q[i] <= wr_data;
    end
    assign regs[i*8 +: 8] = reg_q[i];
  end

  // Unmapped addresses fall through to zero
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = reg_q[i];
  end
endmodule

// File: rtl/csp_serial_port.sv
module csp_serial_port #(
  parameter int HALF      = 1,
  parameter int FRAME_LEN = 256,
  parameter int SEC_START = 128,
  parameter int NREG      = 8
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              fc,
  input  logic [15:0]       rx_sample,
  output logic              sclk,
  output logic              fsync,
  output logic              sdo,
  output logic [15:0]       tx_sample,
  output logic              tx_strobe,
  output logic [NREG*8-1:0] reg_out
);
  import csp_pkg::*;

  localparam int POS_W = $clog2(FRAME_LEN);
  typedef logic [POS_W-1:0] pos_t;
  localparam pos_t LAST_POS  = pos_t'(FRAME_LEN - 1);
  localparam pos_t PRI_LAST  = pos_t'(SLOT_W - 1);
  localparam pos_t SEC_FIRST = pos_t'(SEC_START);
  localparam pos_t SEC_DATA  = pos_t'(SEC_START + SLOT_W - 8);
  localparam pos_t SEC_LAST  = pos_t'(SEC_START + SLOT_W - 1);

  // Named internal events (observed by the bound checker)
  logic              rise_ev, fall_ev;
  pos_t              pos_q, pos_nx;
  logic              sec_act;
  logic              sb_mode;
  logic              in_pri, in_sec;
  logic [SLOT_W-1:0] in_sh, in_word, out_sh;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data, rd_byte;

  csp_clkgen #(.HALF(HALF)) u_clk (
    .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  csp_regfile #(.NREG(NREG)) u_regs (
    .mclk(mclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs(reg_out)
  );

  assign sb_mode = reg_out[SB_REG*8 + SB_BIT];
  assign pos_nx  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  assign in_pri  = (pos_q <= PRI_LAST);
  assign in_sec  = sec_act && (pos_q >= SEC_FIRST) && (pos_q <= SEC_LAST);
  assign in_word = {in_sh[SLOT_W-2:0], sdi};

  // Command fields: address is complete after bit period SEC_DATA-1
  assign rd_addr = in_sh[ADDR_W-1:0];
  assign rd_byte = in_sh[7] ? rd_data : 8'h00;
  assign wr_en   = fall_ev && sec_act && (pos_q == SEC_LAST) && !in_word[15];
  assign wr_addr = in_word[12:8];
  assign wr_data = in_word[7:0];

  // Launch side: position, sync and serial output change on sclk rise
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= LAST_POS;
      fsync  <= 1'b0;
      sdo    <= 1'b0;
      out_sh <= '0;
    end else if (rise_ev) begin
      pos_q <= pos_nx;
      fsync <= (pos_nx == '0) || (sec_act && pos_nx == SEC_FIRST);
      if (pos_nx == '0) begin
        sdo    <= rx_sample[15];
        out_sh <= {rx_sample[14:0], 1'b0};
      end else if (sec_act && pos_nx == SEC_DATA) begin
        sdo    <= rd_byte[7];
        out_sh <= {rd_byte[6:0], 9'b0};
      end else if ((pos_nx <= PRI_LAST) ||
                   (sec_act && pos_nx > SEC_DATA && pos_nx <= SEC_LAST)) begin
        sdo    <= out_sh[15];
        out_sh <= {out_sh[14:0], 1'b0};
      end else begin
        sdo <= 1'b0;
      end
    end
  end

  // Capture side: sdi sampled on sclk fall
  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      in_sh     <= '0;
      sec_act   <= 1'b0;
      tx_sample <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= 1'b0;
      if (fall_ev && (in_pri || in_sec)) begin
        in_sh <= in_word;
        if (pos_q == PRI_LAST) begin
          tx_sample <= csp_tx_mask(in_word, sb_mode);
          tx_strobe <= 1'b1;
          sec_act   <= csp_request(sb_mode, in_word[0], fc);
        end else if (pos_q == SEC_LAST) begin
          sec_act <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/csp_sp_checker.sv
module csp_sp_checker #(
  parameter int NREG  = 8,
  parameter int POS_W = 8
) (
  input logic              mclk,
  input logic              rst_n,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic [POS_W-1:0]  pos_q,
  input logic              sec_act,
  input logic              fsync,
  input logic              sdo,
  input logic              tx_strobe,
  input logic              wr_en,
  input logic [4:0]        wr_addr,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] reg_out
);
  localparam logic [POS_W-1:0] P_PRI_LAST = POS_W'(15);
  localparam logic [POS_W-1:0] P_SEC      = POS_W'(128);
  localparam logic [POS_W-1:0] P_SEC_DAT  = POS_W'(136);
  localparam logic [POS_W-1:0] P_SEC_END  = POS_W'(143);

  p_edges_exclusive_r1: assert property (@(posedge mclk) disable iff (!rst_n)
    !(rise_ev && fall_ev));

  p_fsync_place_r1: assert property (@(posedge mclk) disable iff (!rst_n)
    fsync |-> (pos_q == '0 || pos_q == P_SEC));

  p_sec_sync_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    (fsync && pos_q == P_SEC) |-> sec_act);

  p_strobe_slot_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    tx_strobe |-> (pos_q == P_PRI_LAST));

  p_sdo_quiet_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    ((pos_q > P_PRI_LAST && pos_q < P_SEC_DAT) || pos_q > P_SEC_END) |-> !sdo);

  p_regs_hold_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_out));

  p_write_lands_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    (wr_en && wr_addr < 5'(NREG)) |=> reg_out[$past(wr_addr)*8 +: 8] == $past(wr_data));

  p_unmapped_write_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    (wr_en && wr_addr >= 5'(NREG)) |=> $stable(reg_out));
endmodule

bind csp_serial_port csp_sp_checker #(.NREG(NREG), .POS_W(POS_W)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev), .pos_q(pos_q),
  .sec_act(sec_act), .fsync(fsync), .sdo(sdo), .tx_strobe(tx_strobe), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .reg_out(reg_out)
);

// File: tb/test_csp_serial_port.sv
`timescale 1ns/1ps
module test_csp_serial_port;
  localparam int NREG = 8;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic sdi = 1'b0;
  logic fc = 1'b0;
  logic [15:0] rx_sample = '0;
  logic sclk, fsync, sdo, tx_strobe;
  logic [15:0] tx_sample;
  logic [NREG*8-1:0] reg_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_reg [NREG];

  // frame observations
  logic [15:0] ob_pri, ob_sec;
  logic ob_fs0, ob_fs128, ob_fs_other, ob_sdo_stray;
  realtime t_first, t_last;

  always #2 mclk = ~mclk;

  csp_serial_port #(.NREG(NREG)) i_csp_serial_port (
    .mclk(mclk), .rst_n(rst_n), .sdi(sdi), .fc(fc), .rx_sample(rx_sample),
    .sclk(sclk), .fsync(fsync), .sdo(sdo), .tx_sample(tx_sample),
    .tx_strobe(tx_strobe), .reg_out(reg_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++) check(req, 64'(reg_out[i*8 +: 8]), 64'(exp_reg[i]));
  endtask

  // One full frame, starting just before bit period 0
  task automatic run_frame(input logic [15:0] txw, input logic fcv, input logic [15:0] cmd,
                           input logic [15:0] rxw);
    rx_sample = rxw;
    fc = fcv;
    ob_pri = '0; ob_sec = '0;
    ob_fs0 = 0; ob_fs128 = 0; ob_fs_other = 0; ob_sdo_stray = 0;
    for (int k = 0; k < 256; k++) begin
      @(posedge sclk);
      #1;
      if (k == 0) t_first = $realtime;
      if (k == 255) t_last = $realtime;
      if (k == 0) ob_fs0 = fsync;
      else if (k == 128) ob_fs128 = fsync;
      else if (fsync) ob_fs_other = 1;
      if (k < 16) ob_pri = {ob_pri[14:0], sdo};
      else if (k >= 128 && k < 144) ob_sec = {ob_sec[14:0], sdo};
      else if (sdo) ob_sdo_stray = 1;
      if (k < 16) sdi = txw[15-k];
      else if (k >= 128 && k < 144) sdi = cmd[143-k];
      else sdi = 1'b0;
    end
    fc = 1'b0;
  endtask

  function automatic logic [15:0] wr_cmd(input logic [4:0] a, input logic [7:0] d);
    return {1'b0, 2'b11, a, d};
  endfunction
  function automatic logic [15:0] rd_cmd(input logic [4:0] a);
    return {1'b1, 2'b10, a, 8'h5A};
  endfunction

  task automatic t_reset();
    check("R10 sclk", 64'(sclk), 0);
    check("R10 fsync", 64'(fsync), 0);
    check("R10 sdo", 64'(sdo), 0);
    check("R10 tx_strobe", 64'(tx_strobe), 0);
    check("R10 regs", 64'(reg_out), 0);
  endtask

  task automatic t_plain();
    run_frame(16'h1234, 0, rd_cmd(5'd0), 16'hBEEF);
    check("R1 frame sync", 64'(ob_fs0), 1);
    check("R1 frame length", 64'(longint'(t_last - t_first)), 64'(255 * 8));
    check("R2 rx word", 64'(ob_pri), 64'hBEEF);
    check("R3 tx word", 64'(tx_sample), 64'h1234);
    check("R6 no sec sync", 64'(ob_fs128), 0);
    check("R6 no stray sync", 64'(ob_fs_other), 0);
    check("R6 sdo idle", 64'(ob_sec), 0);
    check("R6 sdo stray", 64'(ob_sdo_stray), 0);
  endtask

  task automatic t_lsb_req();
    run_frame(16'h8001, 0, rd_cmd(5'd0), 16'h0F0F);
    check("R4 lsb opens slot", 64'(ob_fs128), 1);
    check("R3 lsb cleared", 64'(tx_sample), 64'h8000);
    check("R2 rx word", 64'(ob_pri), 64'h0F0F);
  endtask

  task automatic t_write();
    run_frame(16'h0001, 0, wr_cmd(5'd3, 8'hA5), 16'h0000);
    exp_reg[3] = 8'hA5;
    check_regs("R7 write reg3");
    check("R8 sdo zero on write", 64'(ob_sec), 0);
  endtask

  task automatic t_read();
    run_frame(16'h0001, 0, rd_cmd(5'd3), 16'h0000);
    check("R8 read reg3", 64'(ob_sec), 64'h00A5);
    check_regs("R7 read leaves regs");
  endtask

  task automatic t_unmapped();
    run_frame(16'h0001, 0, wr_cmd(5'd20, 8'hFF), 16'h0000);
    check_regs("R9 unmapped write ignored");
    run_frame(16'h0001, 0, rd_cmd(5'd20), 16'h0000);
    check("R9 unmapped reads zero", 64'(ob_sec), 0);
  endtask

  task automatic t_fc_req();
    run_frame(16'h0000, 1, rd_cmd(5'd3), 16'h0000);
    check("R4 fc opens slot", 64'(ob_fs128), 1);
    check("R4 fc read", 64'(ob_sec), 64'h00A5);
  endtask

  task automatic t_sb_mode();
    run_frame(16'h0001, 0, wr_cmd(5'd1, 8'h01), 16'h0000);
    exp_reg[1] = 8'h01;
    check_regs("R5 set 16-bit mode");
    run_frame(16'h4321, 0, wr_cmd(5'd5, 8'h77), 16'h0000);
    check("R5 lsb ignored sync", 64'(ob_fs128), 0);
    check("R5 full tx word", 64'(tx_sample), 64'h4321);
    check_regs("R5 lsb write ignored");
    check("R6 sdo idle", 64'(ob_sdo_stray), 0);
    run_frame(16'h0000, 1, rd_cmd(5'd1), 16'h0000);
    check("R5 fc opens slot", 64'(ob_fs128), 1);
    check("R5 fc read mode reg", 64'(ob_sec), 64'h0001);
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
    repeat (5) @(posedge mclk);
    @(negedge mclk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_lsb_req();
    t_write();
    t_read();
    t_unmapped();
    t_fc_req();
    t_sb_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule